// File: doc/BRIEF.md
# Interrupt State Store with Error-Contained Configuration RAM

This block keeps the state of a small set of private interrupts. Group and priority sit in a RAM whose entries each hold four interrupts' worth of configuration. Every entry is guarded by a single-error-correct, double-error-detect code. Pending, active and enable bits sit in flops beside the RAM. The configuration of every entry is decoded continuously. A single-bit upset is corrected on the fly and scrubbed back into the RAM. A double-bit upset marks all four interrupts of that entry as being in error. Their enables are dropped so that nothing is forwarded on corrupted settings. Their group is then taken as Secure until software rewrites the entry.

Software reaches the block through a simple write strobe with a combinational read. Through it, software programs whole RAM entries, sets and clears enables, raises pending bits and reads back the error vector. Toward the CPU interface, the block offers the best enabled, pending, inactive and error-free interrupt, takes an acknowledge that moves it to active, and takes deactivates that carry a security attribute. A fault-injection input XORs a mask into a chosen stored entry, so that upsets can be provoked.

Top module: `irq_state_store`

## Requirements
- R1: After reset the enable, pending, active and error vectors all read zero, and no forward request is raised.
- R2: Writing entry e (address 0x00+e) stores four slots. Slot k occupies data bits [6k+5:6k]: bit 6k+5 is the group (1 = Non-secure), and bits [6k+4:6k] are the priority. These belong to interrupt 4e+k. Reading the same address returns the corrected slots.
- R3: The forward request names the interrupt that is enabled, pending, not active and not in error, with the lowest priority value. On equal priority the lower number wins. It is low when there is no such interrupt.
- R4: An acknowledge while a request is raised clears that interrupt's pending bit and sets its active bit.
- R5: A single flipped bit in a stored entry does not change the read-back data, the error vector or the forwarding. The entry is rewritten with its corrected value, so a later single flip in another bit is also corrected.
- R6: Two flipped bits in entry e set error bits 4e..4e+3 and clear those four enables. The pending and active bits of those interrupts are kept.
- R7: An interrupt whose entry is in error is never forwarded.
- R8: A Non-secure deactivate of an interrupt in error is ignored. A Secure deactivate of it clears its active bit.
- R9: A Non-secure deactivate clears the active bit only when the interrupt's group is Non-secure. A Secure deactivate always clears it.
- R10: Rewriting an errored entry clears its four error bits. The four enables stay clear until software sets them again.
- R11: The register addresses are as follows. 0x80 sets enables on write and reads the enables. 0x81 clears enables on write and reads pending. 0x82 sets pending on write and reads active. 0x83 reads the error vector. Any other address above the entry range reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | AW | Register address |
| regWdata | input | BUS_W | Write data |
| regRdata | output | BUS_W | Combinational read data for regAddr |
| fwdValid | output | 1 | A forwardable interrupt exists |
| fwdId | output | ID_W | Number of the forwarded interrupt |
| fwdPrio | output | PRIO_W | Its priority |
| fwdAck | input | 1 | Acknowledge of the forwarded interrupt |
| deactStb | input | 1 | Deactivate request |
| deactId | input | ID_W | Interrupt to deactivate |
| deactNs | input | 1 | Deactivate comes from Non-secure software |
| faultStb | input | 1 | Apply fault mask this cycle |
| faultEntry | input | EW | Entry to corrupt |
| faultMask | input | CW | Bits of the stored codeword to flip |

## Verification
The bench keeps the default parameters: 16 interrupts, 5-bit priorities, a 32-bit bus and an 8-bit address. This gives four RAM entries of 24 data bits, each protected by a 30-bit codeword. With so few entries, every entry can be written and read back directly, and the tie-break and cross-entry priority cases can be set up by hand. Single and double flips can also be placed on known codeword bits of one specific entry. The run then checks that only that entry's four interrupts are contained and that the other entries keep forwarding.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

  // Strobes from control to datapath, one per cycle at most of each kind.
  typedef struct packed {
    logic entWr;
    logic scrubWr;
    logic enSet;
    logic enClr;
    logic pendSet;
  } strobe_t;

  localparam int SLOTS = 4;

  // Smallest Hamming parity count covering dw data bits.
  function automatic int calcParity(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/irqs_ctrl.sv
module irqs_ctrl #(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 5,
  parameter int BUS_W   = 32,
  parameter int AW      = 8,
  localparam int NUM_ENT = NUM_IRQ / irqs_pkg::SLOTS,
  localparam int SLOT_W  = PRIO_W + 1,
  localparam int DW      = irqs_pkg::SLOTS * SLOT_W,
  localparam int EW      = $clog2(NUM_ENT)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWr,
  input  logic [AW-1:0]          regAddr,
  input  logic [BUS_W-1:0]       regWdata,
  output logic [BUS_W-1:0]       regRdata,
  input  logic [NUM_ENT-1:0]     sbeVec,
  input  logic [NUM_ENT*DW-1:0]  decData,
  input  logic [NUM_IRQ-1:0]     enable,
  input  logic [NUM_IRQ-1:0]     pend,
  input  logic [NUM_IRQ-1:0]     act,
  input  logic [NUM_IRQ-1:0]     errVec,
  output irqs_pkg::strobe_t      str,
  output logic [EW-1:0]          entIdx,
  output logic [DW-1:0]          entData,
  output logic [EW-1:0]          scrubIdx,
  output logic [NUM_IRQ-1:0]     wMask
);

  logic entHit, regHit;
  logic [1:0] off;
  logic unusedWdata;

  assign entHit = !regAddr[AW-1] && (regAddr[AW-2:EW] == '0);
  assign regHit = regAddr[AW-1] && (regAddr[AW-2:2] == '0);
  assign off    = regAddr[1:0];

  assign entIdx  = regAddr[EW-1:0];
  assign entData = regWdata[DW-1:0];
  assign wMask   = regWdata[NUM_IRQ-1:0];
  assign unusedWdata = ^regWdata;

  // Scrub picks the lowest entry holding a correctable upset.
  always_comb begin
    scrubIdx = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--)
      if (sbeVec[e]) scrubIdx = EW'(e);
  end

  always_comb begin
    str.entWr   = regWr && entHit;
    str.enSet   = regWr && regHit && (off == 2'd0);
    str.enClr   = regWr && regHit && (off == 2'd1);
    str.pendSet = regWr && regHit && (off == 2'd2);
    str.scrubWr = (|sbeVec) && !(regWr && entHit);
  end

  always_comb begin
    regRdata = '0;
    if (entHit) begin
      regRdata = BUS_W'(decData[int'(entIdx)*DW +: DW]);
    end else if (regHit) begin
      case (off)
        2'd0:    regRdata = BUS_W'(enable);
        2'd1:    regRdata = BUS_W'(pend);
        2'd2:    regRdata = BUS_W'(act);
        default: regRdata = BUS_W'(errVec);
      endcase
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(str.entWr && str.scrubWr)); // R5

endmodule

// File: rtl/irqs_datapath.sv
module irqs_datapath #(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 5,
  localparam int NUM_ENT = NUM_IRQ / irqs_pkg::SLOTS,
  localparam int SLOT_W  = PRIO_W + 1,
  localparam int DW      = irqs_pkg::SLOTS * SLOT_W,
  localparam int PAR_W   = irqs_pkg::calcParity(DW),
  localparam int N       = DW + PAR_W,
  localparam int CW      = N + 1,
  localparam int EW      = $clog2(NUM_ENT),
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  irqs_pkg::strobe_t      str,
  input  logic [EW-1:0]          entIdx,
  input  logic [DW-1:0]          entData,
  input  logic [EW-1:0]          scrubIdx,
  input  logic [NUM_IRQ-1:0]     wMask,
  input  logic                   faultStb,
  input  logic [EW-1:0]          faultEntry,
  input  logic [CW-1:0]          faultMask,
  input  logic                   fwdAck,
  input  logic                   deactStb,
  input  logic [ID_W-1:0]        deactId,
  input  logic                   deactNs,
  output logic [NUM_ENT*DW-1:0]  decData,
  output logic [NUM_ENT-1:0]     sbeVec,
  output logic [NUM_IRQ-1:0]     enable,
  output logic [NUM_IRQ-1:0]     pend,
  output logic [NUM_IRQ-1:0]     act,
  output logic [NUM_IRQ-1:0]     errVec,
  output logic                   fwdValid,
  output logic [ID_W-1:0]        fwdId,
  output logic [PRIO_W-1:0]      fwdPrio
);

  // Codeword: bit 0 overall parity, bits 1..N Hamming positions.
  function automatic logic [CW-1:0] eccEncode(input logic [DW-1:0] d);
    logic [CW-1:0] w;
    logic x;
    int k;
    w = '0;
    k = 0;
    for (int i = 1; i <= N; i++)
      if ((i & (i - 1)) != 0) begin
        w[i] = d[k];
        k++;
      end
    for (int j = 0; j < PAR_W; j++) begin
      x = 1'b0;
      for (int i = 1; i <= N; i++)
        if (((i >> j) & 1) == 1) x = x ^ w[i];
      w[1 << j] = x;
    end
    w[0] = ^w[N:1];
    return w;
  endfunction

  // Returns {uncorrectable, corrected, data}.
  function automatic logic [DW+1:0] eccDecode(input logic [CW-1:0] wIn);
    logic [CW-1:0] w;
    logic [DW-1:0] d;
    logic x, ov, ue, se;
    int s, k;
    w  = wIn;
    s  = 0;
    ue = 1'b0;
    se = 1'b0;
    for (int j = 0; j < PAR_W; j++) begin
      x = 1'b0;
      for (int i = 1; i <= N; i++)
        if (((i >> j) & 1) == 1) x = x ^ w[i];
      if (x) s = s | (1 << j);
    end
    ov = ^w;
    if (ov) begin
      se = 1'b1;
      if (s == 0) w[0] = ~w[0];
      else if (s <= N) w[s] = ~w[s];
      else begin
        ue = 1'b1;
        se = 1'b0;
      end
    end else if (s != 0) begin
      ue = 1'b1;
    end
    d = '0;
    k = 0;
    for (int i = 1; i <= N; i++)
      if ((i & (i - 1)) != 0) begin
        d[k] = w[i];
        k++;
      end
    return {ue, se, d};
  endfunction

  logic [CW-1:0] mem    [NUM_ENT];
  logic [CW-1:0] memNxt [NUM_ENT];
  logic [NUM_ENT-1:0] ueVec;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign {ueVec[e], sbeVec[e], decData[e*DW +: DW]} = eccDecode(mem[e]);

    always_comb begin
      memNxt[e] = mem[e];
      if (str.entWr && entIdx == EW'(e))
        memNxt[e] = eccEncode(entData);
      else if (str.scrubWr && scrubIdx == EW'(e))
        memNxt[e] = eccEncode(decData[e*DW +: DW]);
      if (faultStb && faultEntry == EW'(e))
        memNxt[e] = memNxt[e] ^ faultMask;
    end

    always_ff @(posedge clk) begin
      if (!rstN) mem[e] <= '0;
      else       mem[e] <= memNxt[e];
    end
  end

  // Forward selection: lowest priority value, lowest number on a tie.
  always_comb begin
    logic elig;
    logic [PRIO_W-1:0] pr;
    fwdValid = 1'b0;
    fwdId    = '0;
    fwdPrio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      elig = enable[i] && pend[i] && !act[i] && !errVec[i] && !ueVec[i/4];
      pr   = decData[i*SLOT_W +: PRIO_W];
      if (elig && (!fwdValid || pr < fwdPrio)) begin
        fwdValid = 1'b1;
        fwdId    = ID_W'(i);
        fwdPrio  = pr;
      end
    end
  end

  // An unknown group counts as Secure.
  logic deactGrpNs, deactOk;
  assign deactGrpNs = decData[int'(deactId)*SLOT_W + PRIO_W]
                      && !errVec[deactId] && !ueVec[deactId[ID_W-1:2]];
  assign deactOk = !deactNs || deactGrpNs;

  logic [NUM_IRQ-1:0] enN, pendN, actN, errN;
  always_comb begin
    enN   = enable;
    pendN = pend;
    actN  = act;
    errN  = errVec;
    if (str.enSet)   enN   = enN | wMask;
    if (str.enClr)   enN   = enN & ~wMask;
    if (str.pendSet) pendN = pendN | wMask;
    if (deactStb && deactOk) actN[deactId] = 1'b0;
    if (fwdAck && fwdValid) begin
      pendN[fwdId] = 1'b0;
      actN[fwdId]  = 1'b1;
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (str.entWr && int'(entIdx) == i/4) errN[i] = 1'b0;
      else if (ueVec[i/4])                  errN[i] = 1'b1;
      if (ueVec[i/4] || errN[i])            enN[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= '0;
      pend   <= '0;
      act    <= '0;
      errVec <= '0;
    end else begin
      enable <= enN;
      pend   <= pendN;
      act    <= actN;
      errVec <= errN;
    end
  end

  AST_FWD_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (enable[fwdId] && pend[fwdId] && !act[fwdId])); // R3

  AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> !errVec[fwdId]); // R7

  AST_NS_DEACT_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (deactStb && deactNs && errVec[deactId] && act[deactId]) |=> act[$past(deactId)]); // R8

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errVec[i]) |-> !enable[i]); // R6

    AST_ERR_KEEPS_ACT: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(errVec[i]) && !$past(deactStb) && !$past(fwdAck)) |-> (act[i] == $past(act[i]))); // R6
  end

endmodule

// File: rtl/irq_state_store.sv
module irq_state_store #(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 5,
  parameter int BUS_W   = 32,
  parameter int AW      = 8,
  localparam int NUM_ENT = NUM_IRQ / irqs_pkg::SLOTS,
  localparam int SLOT_W  = PRIO_W + 1,
  localparam int DW      = irqs_pkg::SLOTS * SLOT_W,
  localparam int CW      = DW + irqs_pkg::calcParity(DW) + 1,
  localparam int EW      = $clog2(NUM_ENT),
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [AW-1:0]     regAddr,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic              fwdValid,
  output logic [ID_W-1:0]   fwdId,
  output logic [PRIO_W-1:0] fwdPrio,
  input  logic              fwdAck,
  input  logic              deactStb,
  input  logic [ID_W-1:0]   deactId,
  input  logic              deactNs,
  input  logic              faultStb,
  input  logic [EW-1:0]     faultEntry,
  input  logic [CW-1:0]     faultMask
);

  irqs_pkg::strobe_t str;
  logic [EW-1:0]         entIdx, scrubIdx;
  logic [DW-1:0]         entData;
  logic [NUM_IRQ-1:0]    wMask, enable, pend, act, errVec;
  logic [NUM_ENT*DW-1:0] decData;
  logic [NUM_ENT-1:0]    sbeVec;

  irqs_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .BUS_W(BUS_W), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sbeVec(sbeVec),
    .decData(decData), .enable(enable), .pend(pend), .act(act),
    .errVec(errVec), .str(str), .entIdx(entIdx), .entData(entData),
    .scrubIdx(scrubIdx), .wMask(wMask)
  );

  irqs_datapath #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .entIdx(entIdx), .entData(entData),
    .scrubIdx(scrubIdx), .wMask(wMask), .faultStb(faultStb),
    .faultEntry(faultEntry), .faultMask(faultMask), .fwdAck(fwdAck),
    .deactStb(deactStb), .deactId(deactId), .deactNs(deactNs),
    .decData(decData), .sbeVec(sbeVec), .enable(enable), .pend(pend),
    .act(act), .errVec(errVec), .fwdValid(fwdValid), .fwdId(fwdId),
    .fwdPrio(fwdPrio)
  );

endmodule

// File: tb/tb_irq_state_store.sv
module tb_irq_state_store;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic fwdValid;
  logic [3:0] fwdId;
  logic [4:0] fwdPrio;
  logic fwdAck = 1'b0;
  logic deactStb = 1'b0;
  logic [3:0] deactId = '0;
  logic deactNs = 1'b0;
  logic faultStb = 1'b0;
  logic [1:0] faultEntry = '0;
  logic [29:0] faultMask = '0;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  irq_state_store dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .fwdValid(fwdValid),
    .fwdId(fwdId), .fwdPrio(fwdPrio), .fwdAck(fwdAck),
    .deactStb(deactStb), .deactId(deactId), .deactNs(deactNs),
    .faultStb(faultStb), .faultEntry(faultEntry), .faultMask(faultMask)
  );

  function automatic logic [23:0] pk(input logic [3:0] g, input logic [4:0] p0,
                                     input logic [4:0] p1, input logic [4:0] p2,
                                     input logic [4:0] p3);
    return {g[3], p3, g[2], p2, g[1], p1, g[0], p0};
  endfunction

  localparam logic [23:0] ENT0 = 24'({1'b1, 5'd20, 1'b1, 5'd3, 1'b0, 5'd3, 1'b1, 5'd10});

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic regW(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regR(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic chkReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    regR(a, d);
    chk(req, d, exp);
  endtask

  task automatic chkFwd(input string req, input logic v, input logic [3:0] id, input logic [4:0] p);
    chk(req, {27'd0, fwdValid}, {31'd0, v});
    if (v) begin
      chk(req, {28'd0, fwdId}, {28'd0, id});
      chk(req, {27'd0, fwdPrio}, {27'd0, p});
    end
  endtask

  task automatic ack();
    @(negedge clk); fwdAck = 1'b1;
    @(negedge clk); fwdAck = 1'b0;
  endtask

  task automatic deact(input logic [3:0] id, input logic ns);
    @(negedge clk); deactStb = 1'b1; deactId = id; deactNs = ns;
    @(negedge clk); deactStb = 1'b0;
  endtask

  task automatic fault(input logic [1:0] e, input logic [29:0] m);
    @(negedge clk); faultStb = 1'b1; faultEntry = e; faultMask = m;
    @(negedge clk); faultStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    chkReg("R1 enable", 8'h80, 0);
    chkReg("R1 pending", 8'h81, 0);
    chkReg("R1 active", 8'h82, 0);
    chkReg("R1 error", 8'h83, 0);
    chkFwd("R1 fwd", 1'b0, 0, 0);
  endtask

  task automatic tConfig();
    regW(8'h00, 32'(ENT0));
    regW(8'h01, 32'(pk(4'b1011, 5'd1, 5'd7, 5'd7, 5'd31)));
    regW(8'h02, 32'(pk(4'b1111, 5'd15, 5'd15, 5'd15, 5'd15)));
    regW(8'h03, 32'(pk(4'b1111, 5'd15, 5'd15, 5'd15, 5'd15)));
    chkReg("R2 entry0", 8'h00, 32'(ENT0));
    chkReg("R2 entry1", 8'h01, 32'(pk(4'b1011, 5'd1, 5'd7, 5'd7, 5'd31)));
    chkReg("R2 entry3", 8'h03, 32'(pk(4'b1111, 5'd15, 5'd15, 5'd15, 5'd15)));
    chkReg("R11 unmapped", 8'h10, 0);
    chkReg("R11 unmapped high", 8'h84, 0);
  endtask

  task automatic tForward();
    regW(8'h80, 32'hFFFF);
    chkFwd("R3 none pending", 1'b0, 0, 0);
    regW(8'h82, 32'h0007);
    chkFwd("R3 tie lower id", 1'b1, 4'd1, 5'd3);
    regW(8'h82, 32'h0010);
    chkFwd("R3 cross entry", 1'b1, 4'd4, 5'd1);
    regW(8'h81, 32'h0010);
    chkFwd("R3 disabled skipped", 1'b1, 4'd1, 5'd3);
    chkReg("R11 enable readback", 8'h80, 32'hFFEF);
  endtask

  task automatic tAck();
    ack();
    chkReg("R4 pending", 8'h81, 32'h0015);
    chkReg("R4 active", 8'h82, 32'h0002);
    chkFwd("R4 next fwd", 1'b1, 4'd2, 5'd3);
  endtask

  task automatic tDeactGroup();
    deact(4'd1, 1'b1);
    chkReg("R9 ns on secure ignored", 8'h82, 32'h0002);
    deact(4'd1, 1'b0);
    chkReg("R9 secure deact", 8'h82, 32'h0000);
    ack();
    chkReg("R9 ack id2", 8'h82, 32'h0004);
    deact(4'd2, 1'b1);
    chkReg("R9 ns on ns group", 8'h82, 32'h0000);
    chkFwd("R9 fwd after", 1'b1, 4'd0, 5'd10);
  endtask

  task automatic tSingle();
    fault(2'd0, 30'h8);
    chkReg("R5 readback 1st", 8'h00, 32'(ENT0));
    chkReg("R5 error 1st", 8'h83, 0);
    fault(2'd0, 30'h20);
    chkReg("R5 readback 2nd", 8'h00, 32'(ENT0));
    chkReg("R5 error 2nd", 8'h83, 0);
    chkFwd("R5 fwd", 1'b1, 4'd0, 5'd10);
  endtask

  task automatic tDouble();
    regW(8'h82, 32'h0060);
    chkFwd("R3 prio over id", 1'b1, 4'd5, 5'd7);
    ack();
    chkFwd("R3 after ack", 1'b1, 4'd6, 5'd7);
    fault(2'd1, 30'h208);
    chkReg("R6 error vector", 8'h83, 32'h00F0);
    chkReg("R6 enables", 8'h80, 32'hFF0F);
    chkReg("R6 pending kept", 8'h81, 32'h0051);
    chkReg("R6 active kept", 8'h82, 32'h0020);
    chkFwd("R7 errored skipped", 1'b1, 4'd0, 5'd10);
    regW(8'h80, 32'h0040);
    chkFwd("R7 enable ignored while errored", 1'b1, 4'd0, 5'd10);
    deact(4'd5, 1'b1);
    chkReg("R8 ns deact ignored", 8'h82, 32'h0020);
    deact(4'd5, 1'b0);
    chkReg("R8 secure deact", 8'h82, 32'h0000);
  endtask

  task automatic tRewrite();
    regW(8'h01, 32'(pk(4'b1011, 5'd1, 5'd7, 5'd7, 5'd31)));
    chkReg("R10 error cleared", 8'h83, 0);
    chkReg("R10 enables stay off", 8'h80, 32'hFF0F);
    chkReg("R10 readback", 8'h01, 32'(pk(4'b1011, 5'd1, 5'd7, 5'd7, 5'd31)));
    chkFwd("R10 not forwarded", 1'b1, 4'd0, 5'd10);
    regW(8'h80, 32'h0040);
    chkFwd("R10 re-enabled", 1'b1, 4'd6, 5'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tConfig();
    tForward();
    tAck();
    tDeactGroup();
    tSingle();
    tDouble();
    tRewrite();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule